// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the 32 pins of one GPIO bank, arranged as 4 ports of 8 pins, and turns pin activity into latched interrupt status. Each pin has a 3-bit trigger type that selects one of five detection modes: level high, level low, rising edge, falling edge or both edges. A detected condition sets that pin's status bit. The bit stays set until software clears it with a write-one-to-clear strobe. The status bits are ANDed with per-pin enables and ORed across the whole bank to form one bank interrupt line.

The pin inputs are expected to be synchronized to `clk` already. The trigger-type words, enables and clear strobes come from a register file outside this block.

Edge-triggered pins are meant to be cleared before their event is serviced. For that reason a clear never discards an edge that arrives in the same cycle. After reset, edge detection is armed only once a first pin sample has been taken, so releasing reset cannot produce a false edge.

Top module: `gpio_irq_bank`

## Requirements
- R1: The trigger type of port p is the 24-bit word `trig_cfg[p*24 +: 24]`. For pin n of that port, bit n is the polarity (1 = high or rising), bit n+8 selects edge mode (1) over level mode (0), and bit n+16 selects detection on both edges. Status, enable, pin and clear-mask bit p*8+n all belong to that same pin.
- R2: A pin typed as rising edge (polarity 1, edge 1, both 0) sets its status bit one clock after a low-to-high transition, and not after a high-to-low transition.
- R3: A pin typed as falling edge (polarity 0, edge 1, both 0) sets its status bit on a high-to-low transition, and not on a low-to-high transition.
- R4: A pin typed as both edges (edge 1, both 1) sets its status bit on either transition.
- R5: A pin typed as level high (polarity 1, edge 0) has its status set on every clock edge at which the pin is high. A clear only takes effect on a clock edge at which the pin is low.
- R6: A pin typed as level low (polarity 0, edge 0, both 0) behaves as in R5 with the active level inverted.
- R7: When `clr_wr[p]` is 1, each bit of `clr_mask` in port p's lanes that is 1 clears the matching status bit on that clock edge. Mask bits that are 0, and mask bits in ports whose `clr_wr` is 0, have no effect. Status bits with no clear stay set.
- R8: If a detected event and a clear hit the same status bit on the same clock edge, the bit stays set.
- R9: After an edge-mode status bit has been cleared, a later edge of the selected kind sets it again.
- R10: `bank_irq` is 1 exactly when some status bit is 1 and its `irq_en` bit is 1. It changes in the same cycle as the status or enable that causes it.
- R11: While reset is asserted, `int_status` and `bank_irq` are 0. Pin levels held through reset and its release cause no edge event.
- R12: A change of the trigger type alone, with steady pins and no level-mode active level, sets no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | 32 | Synchronized pin levels, bit p*8+n = pin n of port p |
| trig_cfg | input | 96 | Four 24-bit trigger-type words, port p at bits p*24 and up |
| irq_en | input | 32 | Per-pin interrupt enable |
| clr_wr | input | 4 | Per-port clear write strobe |
| clr_mask | input | 32 | Write-one-to-clear data, lanes as for status |
| int_status | output | 32 | Latched interrupt status |
| bank_irq | output | 1 | OR of enabled status over the bank |

## Verification
Some properties are checked by assertions on every cycle. Edge outputs only fire on a real transition of the pin. A clear without an event drops the bit. An event always wins over a clear. No status bit rises without an event, and no bit drops without a clear. The bank line stays low when every enable is off or no status is set. Other behaviour can only be shown by the directed scenarios, because it depends on decoding each 3-bit type: which transitions each of the five modes accepts or ignores, how level mode refuses a clear while the pin is active, how port lanes select clear masks, and that no edge appears across reset or a type change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Decoded per-pin trigger selection.
  typedef struct packed {
    logic both;     // detect on either edge
    logic edge_md;  // 1 = edge mode, 0 = level mode
    logic pol;      // 1 = high / rising, 0 = low / falling
  } trig_t;

  // Per-pin detected condition for one cycle.
  function automatic logic pin_event(input trig_t t, input logic lvl,
                                     input logic rise, input logic fall);
    logic hit;
    if (!t.edge_md)
      hit = (lvl == t.pol);
    else if (t.both)
      hit = rise | fall;
    else if (t.pol)
      hit = rise;
    else
      hit = fall;
    return hit;
  endfunction

  // Status update: a fresh event always survives a clear.
  function automatic logic status_step(input logic evt, input logic cur,
                                       input logic clr);
    return evt | (cur & ~clr);
  endfunction

endpackage

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  logic [WIDTH-1:0] prev_q;
  logic             primed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= lvl_i;
      primed_q <= 1'b1;
    end
  end

  assign rise_o = primed_q ? (lvl_i & ~prev_q) : '0;
  assign fall_o = primed_q ? (~lvl_i & prev_q) : '0;

  AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o & ~(lvl_i & ~$past(lvl_i))) == '0); // R2

  AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_o & ~(~lvl_i & $past(lvl_i))) == '0); // R3

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o & fall_o) == '0); // R4

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CFG_W = 3 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic             clr_wr_i,
  input  logic [WIDTH-1:0] clr_mask_i,
  output logic [WIDTH-1:0] status_o,
  output logic             pend_o
);

  logic [WIDTH-1:0] rise_w;
  logic [WIDTH-1:0] fall_w;
  logic [WIDTH-1:0] evt_w;
  logic [WIDTH-1:0] clr_w;
  logic [WIDTH-1:0] status_q;

  gpio_irq_edge #(.WIDTH(WIDTH)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  assign clr_w = clr_mask_i & {WIDTH{clr_wr_i}};

  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    trig_t trig_w;
    assign trig_w.pol     = cfg_i[n];
    assign trig_w.edge_md = cfg_i[n + WIDTH];
    assign trig_w.both    = cfg_i[n + 2 * WIDTH];
    assign evt_w[n] = pin_event(trig_w, lvl_i[n], rise_w[n], fall_w[n]);

    always_ff @(posedge clk) begin
      if (!rst_n) status_q[n] <= 1'b0;
      else        status_q[n] <= status_step(evt_w[n], status_q[n], clr_w[n]);
    end
  end

  assign status_o = status_q;
  assign pend_o   = |(status_q & en_i);

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_q & $past(clr_w & ~evt_w)) == '0); // R7

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_q & $past(evt_w)) == $past(evt_w)); // R8

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(status_q) & ~$past(clr_w) & ~status_q) == '0); // R7

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_q & ~$past(status_q) & ~$past(evt_w)) == '0); // R12

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  localparam int PINS     = NUM_PORTS * PORT_W,
  localparam int CFG_W    = 3 * PORT_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PINS-1:0]            pin_lvl,
  input  logic [NUM_PORTS*CFG_W-1:0] trig_cfg,
  input  logic [PINS-1:0]            irq_en,
  input  logic [NUM_PORTS-1:0]       clr_wr,
  input  logic [PINS-1:0]            clr_mask,
  output logic [PINS-1:0]            int_status,
  output logic                       bank_irq
);

  logic [NUM_PORTS-1:0] port_pend;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_irq_port #(.WIDTH(PORT_W)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_i      (pin_lvl[p*PORT_W +: PORT_W]),
      .cfg_i      (trig_cfg[p*CFG_W +: CFG_W]),
      .en_i       (irq_en[p*PORT_W +: PORT_W]),
      .clr_wr_i   (clr_wr[p]),
      .clr_mask_i (clr_mask[p*PORT_W +: PORT_W]),
      .status_o   (int_status[p*PORT_W +: PORT_W]),
      .pend_o     (port_pend[p])
    );
  end

  assign bank_irq = |port_pend;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !bank_irq); // R10

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    bank_irq |-> (int_status != '0)); // R10

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(!rst_n) |-> (int_status == '0)); // R11

endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_lvl = 32'hFFFF_0000;
  logic [95:0] trig_cfg = {4{24'h00FFFF}};
  logic [31:0] irq_en = '0;
  logic [3:0]  clr_wr = '0;
  logic [31:0] clr_mask = '0;
  logic [31:0] int_status;
  logic        bank_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .trig_cfg(trig_cfg),
    .irq_en(irq_en), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .int_status(int_status), .bank_irq(bank_irq)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // code = {both, edge, pol}
  task automatic set_type(input int pin, input logic [2:0] code);
    int p;
    int n;
    p = pin / 8;
    n = pin % 8;
    trig_cfg[p*24 + n]      = code[0];
    trig_cfg[p*24 + 8 + n]  = code[1];
    trig_cfg[p*24 + 16 + n] = code[2];
  endtask

  task automatic clr_pulse(input logic [3:0] wr, input logic [31:0] mask);
    clr_wr = wr;
    clr_mask = mask;
    step();
    clr_wr = '0;
    clr_mask = '0;
  endtask

  task automatic t_reset();
    repeat (3) step();
    check("R11 status in reset", int_status, 32'h0);
    check("R11 irq in reset", {31'b0, bank_irq}, 32'h0);
    rst_n = 1'b1;
    repeat (3) step();
    check("R11 no edge from reset", int_status, 32'h0);
  endtask

  task automatic t_rise();
    pin_lvl[1] = 1'b1; step();
    check("R2 rising sets", int_status, 32'h2);
    clr_pulse(4'b0001, 32'h2);
    check("R7 clear drops", int_status, 32'h0);
    pin_lvl[1] = 1'b0; step();
    check("R2 falling ignored", int_status, 32'h0);
    pin_lvl[1] = 1'b1; step();
    check("R9 edge after clear", int_status, 32'h2);
    clr_pulse(4'b0001, 32'h2);
  endtask

  task automatic t_fall();
    set_type(9, 3'b010); step();
    pin_lvl[9] = 1'b1; step();
    check("R3 rising ignored", int_status, 32'h0);
    pin_lvl[9] = 1'b0; step();
    check("R3 falling sets", int_status, 32'h200);
    clr_pulse(4'b0010, 32'h200);
    check("R3 cleared", int_status, 32'h0);
  endtask

  task automatic t_both();
    set_type(17, 3'b110); step();
    check("R1 both type no event", int_status, 32'h0);
    pin_lvl[17] = 1'b0; step();
    check("R4 fall sets", int_status, 32'h0002_0000);
    clr_pulse(4'b0100, 32'h0002_0000);
    pin_lvl[17] = 1'b1; step();
    check("R4 rise sets", int_status, 32'h0002_0000);
    clr_pulse(4'b0100, 32'h0002_0000);
    check("R4 cleared", int_status, 32'h0);
  endtask

  task automatic t_level_high();
    set_type(24, 3'b001); step();
    check("R5 active level sets", int_status, 32'h0100_0000);
    clr_pulse(4'b1000, 32'h0100_0000);
    check("R5 clear refused while high", int_status, 32'h0100_0000);
    pin_lvl[24] = 1'b0; step();
    check("R5 held after leaving level", int_status, 32'h0100_0000);
    clr_pulse(4'b1000, 32'h0100_0000);
    check("R5 clear once low", int_status, 32'h0);
    set_type(24, 3'b011); step();
  endtask

  task automatic t_level_low();
    set_type(25, 3'b000); step();
    check("R6 inactive high", int_status, 32'h0);
    pin_lvl[25] = 1'b0; step();
    check("R6 low sets", int_status, 32'h0200_0000);
    clr_pulse(4'b1000, 32'h0200_0000);
    check("R6 clear refused while low", int_status, 32'h0200_0000);
    pin_lvl[25] = 1'b1; step();
    clr_pulse(4'b1000, 32'h0200_0000);
    check("R6 clear once high", int_status, 32'h0);
    set_type(25, 3'b011); step();
  endtask

  task automatic t_same_cycle();
    pin_lvl[2] = 1'b1; step();
    check("R2 pin2 sets", int_status, 32'h4);
    pin_lvl[2] = 1'b0; step();
    pin_lvl[2] = 1'b1;
    clr_pulse(4'b0001, 32'h4);
    check("R8 edge beats clear", int_status, 32'h4);
    clr_pulse(4'b0001, 32'h4);
    check("R8 later clear", int_status, 32'h0);
  endtask

  task automatic t_mask();
    pin_lvl[1] = 1'b0; step();
    pin_lvl[1] = 1'b1; pin_lvl[3] = 1'b1; step();
    check("R7 two set", int_status, 32'hA);
    clr_pulse(4'b0010, 32'h8);
    check("R7 other port strobe ignored", int_status, 32'hA);
    clr_pulse(4'b0001, 32'h2);
    check("R7 zero mask bit kept", int_status, 32'h8);
    clr_pulse(4'b0001, 32'h8);
    check("R7 last clear", int_status, 32'h0);
  endtask

  task automatic t_irq();
    pin_lvl[30] = 1'b0; step();
    pin_lvl[30] = 1'b1; step();
    check("R10 status30", int_status, 32'h4000_0000);
    check("R10 irq off when disabled", {31'b0, bank_irq}, 32'h0);
    irq_en = 32'h20; step();
    check("R10 other enable", {31'b0, bank_irq}, 32'h0);
    irq_en = 32'h4000_0000; step();
    check("R10 irq on", {31'b0, bank_irq}, 32'h1);
    clr_pulse(4'b1000, 32'h4000_0000);
    check("R10 irq drops with status", {31'b0, bank_irq}, 32'h0);
    irq_en = '0;
  endtask

  task automatic t_type_change();
    set_type(4, 3'b010); step();
    set_type(4, 3'b110); step();
    set_type(4, 3'b011); step();
    set_type(20, 3'b010); step();
    set_type(20, 3'b110); step();
    set_type(20, 3'b011); step();
    check("R12 type change no status", int_status, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_level_high();
    t_level_low();
    t_same_cycle();
    t_mask();
    t_irq();
    t_type_change();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule